// File: doc/BRIEF.md
# Message-to-Indicator Interrupt Logic

This block turns message-signalled interrupt writes from devices into adapter interrupts. Each 32-bit message word holds a function id and a vector number. The block looks the function id up in a table of per-slot routing registers. It then sets an indicator bit and a summary bit in byte-wide memory. Each bit is set with its own locked read-modify-write sequence. An interrupt word is raised only when the summary byte held no bits before the update. Bits are numbered MSB-first within each byte.

A message with no matching function produces an error event and makes no memory access. A memory fault on either read produces an adapter-indicator error event. Reads of the message port always return all ones. The routing table is loaded through a simple slot write port.

Top module: `msi_ind_irq`

## Requirements
- R1: The vector number is `wr_data_i[VEC_W-1:0]` and the function id is `wr_data_i[31:VEC_W]`.
- R2: The lookup uses the lowest-numbered slot whose valid flag is set and whose id equals the function id. Slots with a clear valid flag never match.
- R3: When no slot matches, the block makes no memory request. In the cycle after acceptance it pulses `evt_valid_o` with `evt_kind_o`=0, `evt_fid_o`=function id and `evt_qual_o`=vector shifted left by QUAL_VEC_LSB (16 by default).
- R4: Let s be the indicator offset plus the vector. The indicator byte address is indicator base + s/8, and the mask is 0x80 >> (s mod 8).
- R5: The summary byte address is summary base + summary offset/8, and the mask is 0x80 >> (summary offset mod 8).
- R6: Each bit is set by a read, then a write of old|mask to the same address. `mem_lock_o` stays high from the read grant to the write grant. The indicator byte is written before the summary byte.
- R7: `irq_valid_o` pulses once, in the cycle after the summary write grant, only when the old summary byte was 0x00. `irq_word_o` then has bit 31 set, bit 30 clear, the slot's 3-bit interrupt class in bits 29:27, and bits 26:0 zero.
- R8: A read error on a byte pulses `evt_valid_o` with `evt_kind_o`=1, `evt_fid_o`=0 and `evt_qual_o`=0, and that byte is not written. After an indicator error the summary update still runs. After a summary error no interrupt is raised.
- R9: Every `rd_valid_i` gives `rd_valid_o` one cycle later with `rd_data_o`=0xFFFFFFFF. This also holds while a message is in progress.
- R10: `wr_ready_o` is low from the cycle after a matching message is accepted until its processing ends.
- R11: After reset, `wr_ready_o` is high and the block drives no memory request, interrupt, event or read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Message write strobe |
| wr_data_i | input | 32 | Message word (function id and vector) |
| wr_ready_o | output | 1 | Block idle, message accepted |
| rd_valid_i | input | 1 | Read of the message port |
| rd_valid_o | output | 1 | Read response strobe |
| rd_data_o | output | 32 | Read response data |
| cfg_we_i | input | 1 | Routing slot write strobe |
| cfg_slot_i | input | IDX_W | Slot index written |
| cfg_valid_i | input | 1 | Slot present flag |
| cfg_fid_i | input | FID_W | Slot function id |
| cfg_ind_base_i | input | ADDR_W | Indicator area base byte address |
| cfg_ind_off_i | input | OFF_W | Indicator bit offset |
| cfg_sum_base_i | input | ADDR_W | Summary area base byte address |
| cfg_sum_off_i | input | OFF_W | Summary bit offset |
| cfg_isc_i | input | 3 | Interrupt class |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (else read) |
| mem_lock_o | output | 1 | Memory held for read-modify-write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_gnt_i | input | 1 | Request granted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data |
| mem_err_i | input | 1 | Read failed (with rvalid) |
| irq_valid_o | output | 1 | Interrupt word strobe |
| irq_word_o | output | 32 | Interrupt word |
| evt_valid_o | output | 1 | Error event strobe |
| evt_kind_o | output | 1 | 0 no function, 1 indicator fault |
| evt_fid_o | output | FID_W | Event function id |
| evt_qual_o | output | 32 | Event qualifier word |

## Verification
Two functions can fall in the same cycle. A port read can arrive in the middle of a read-modify-write sequence, and a new message can arrive while the block is busy. The bench issues a read right after accepting a matching message. It then requires `wr_ready_o` low and an all-ones response one cycle later. The indicator and summary bytes must still end with exactly the values the arithmetic model predicts.

Two slots share one summary byte, so interrupts fire only on the transition from zero. The memory grant stalls in a pseudo-random pattern, which stretches the lock window that the bench checks.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_IND_RD, ST_IND_WAIT, ST_IND_WR, ST_SUM_RD, ST_SUM_WAIT, ST_SUM_WR
  } state_e;

  typedef enum logic {
    EVT_NO_FUNC   = 1'b0,
    EVT_IND_FAULT = 1'b1
  } evt_kind_e;

  localparam int ISC_W       = 3;
  localparam int IRQ_ISC_LSB = 27;
  localparam int IRQ_AI_BIT  = 31;
endpackage

// File: rtl/msi_route_lookup.sv
module msi_route_lookup #(
  parameter int NUM_SLOTS = 32,
  parameter int FID_W     = 24,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0]            slot_valid_i,
  input  logic [NUM_SLOTS-1:0][FID_W-1:0] slot_fid_i,
  input  logic [FID_W-1:0]                fid_i,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                idx_o
);
  logic [NUM_SLOTS-1:0] match;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_match
    assign match[g] = slot_valid_i[g] && (slot_fid_i[g] == fid_i);
  end

  // lowest slot wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (hit_o) begin
      // R2
      lookup_match_chk: assert (slot_valid_i[idx_o] && (slot_fid_i[idx_o] == fid_i));
    end
  end
endmodule

// File: rtl/msi_bit_locate.sv
module msi_bit_locate #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 12,
  parameter int VEC_W  = 8,
  localparam int SUM_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        mask_o
);
  logic [SUM_W-1:0] bit_pos;

  assign bit_pos = SUM_W'(off_i) + SUM_W'(vec_i);
  assign addr_o  = base_i + ADDR_W'(bit_pos[SUM_W-1:3]);
  // bit 0 of the bit number is the byte's MSB
  assign mask_o  = 8'h80 >> bit_pos[2:0];
endmodule

// File: rtl/msi_ind_irq.sv
module msi_ind_irq
  import msi_ind_pkg::*;
#(
  parameter int NUM_SLOTS    = 32,
  parameter int VEC_W        = 8,
  parameter int ADDR_W       = 16,
  parameter int OFF_W        = 12,
  parameter int QUAL_VEC_LSB = 16,
  localparam int FID_W       = 32 - VEC_W,
  localparam int IDX_W       = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [31:0]       wr_data_i,
  output logic              wr_ready_o,
  input  logic              rd_valid_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_slot_i,
  input  logic              cfg_valid_i,
  input  logic [FID_W-1:0]  cfg_fid_i,
  input  logic [ADDR_W-1:0] cfg_ind_base_i,
  input  logic [OFF_W-1:0]  cfg_ind_off_i,
  input  logic [ADDR_W-1:0] cfg_sum_base_i,
  input  logic [OFF_W-1:0]  cfg_sum_off_i,
  input  logic [2:0]        cfg_isc_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_err_i,
  output logic              irq_valid_o,
  output logic [31:0]       irq_word_o,
  output logic              evt_valid_o,
  output logic              evt_kind_o,
  output logic [FID_W-1:0]  evt_fid_o,
  output logic [31:0]       evt_qual_o
);
  // routing register file
  logic [NUM_SLOTS-1:0]             rt_valid_q;
  logic [NUM_SLOTS-1:0][FID_W-1:0]  rt_fid_q;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] rt_ind_base_q, rt_sum_base_q;
  logic [NUM_SLOTS-1:0][OFF_W-1:0]  rt_ind_off_q, rt_sum_off_q;
  logic [NUM_SLOTS-1:0][ISC_W-1:0]  rt_isc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rt_valid_q    <= '0;
      rt_fid_q      <= '0;
      rt_ind_base_q <= '0;
      rt_sum_base_q <= '0;
      rt_ind_off_q  <= '0;
      rt_sum_off_q  <= '0;
      rt_isc_q      <= '0;
    end else if (cfg_we_i) begin
      rt_valid_q[cfg_slot_i]    <= cfg_valid_i;
      rt_fid_q[cfg_slot_i]      <= cfg_fid_i;
      rt_ind_base_q[cfg_slot_i] <= cfg_ind_base_i;
      rt_sum_base_q[cfg_slot_i] <= cfg_sum_base_i;
      rt_ind_off_q[cfg_slot_i]  <= cfg_ind_off_i;
      rt_sum_off_q[cfg_slot_i]  <= cfg_sum_off_i;
      rt_isc_q[cfg_slot_i]      <= cfg_isc_i;
    end
  end

  logic [FID_W-1:0]  in_fid;
  logic [VEC_W-1:0]  in_vec;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;
  logic [ADDR_W-1:0] ind_addr_d, sum_addr_d;
  logic [7:0]        ind_mask_d, sum_mask_d;

  assign in_fid = wr_data_i[31:VEC_W];
  assign in_vec = wr_data_i[VEC_W-1:0];

  msi_route_lookup #(.NUM_SLOTS(NUM_SLOTS), .FID_W(FID_W)) u_lookup (
    .slot_valid_i (rt_valid_q),
    .slot_fid_i   (rt_fid_q),
    .fid_i        (in_fid),
    .hit_o        (lk_hit),
    .idx_o        (lk_idx)
  );

  msi_bit_locate #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VEC_W(VEC_W)) u_ind_loc (
    .base_i (rt_ind_base_q[lk_idx]),
    .off_i  (rt_ind_off_q[lk_idx]),
    .vec_i  (in_vec),
    .addr_o (ind_addr_d),
    .mask_o (ind_mask_d)
  );

  msi_bit_locate #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VEC_W(VEC_W)) u_sum_loc (
    .base_i (rt_sum_base_q[lk_idx]),
    .off_i  (rt_sum_off_q[lk_idx]),
    .vec_i  ('0),
    .addr_o (sum_addr_d),
    .mask_o (sum_mask_d)
  );

  state_e            state_q;
  logic [ADDR_W-1:0] ind_addr_q, sum_addr_q;
  logic [7:0]        ind_mask_q, sum_mask_q, old_q;
  logic [ISC_W-1:0]  isc_q;
  logic              evt_valid_q, evt_kind_q, irq_valid_q, rd_valid_q;
  logic [FID_W-1:0]  evt_fid_q;
  logic [31:0]       evt_qual_q, irq_word_q;
  logic              on_ind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ind_addr_q  <= '0;
      sum_addr_q  <= '0;
      ind_mask_q  <= '0;
      sum_mask_q  <= '0;
      old_q       <= '0;
      isc_q       <= '0;
      evt_valid_q <= 1'b0;
      evt_kind_q  <= 1'b0;
      evt_fid_q   <= '0;
      evt_qual_q  <= '0;
      irq_valid_q <= 1'b0;
      irq_word_q  <= '0;
      rd_valid_q  <= 1'b0;
    end else begin
      evt_valid_q <= 1'b0;
      irq_valid_q <= 1'b0;
      rd_valid_q  <= rd_valid_i;
      unique case (state_q)
        ST_IDLE: if (wr_valid_i) begin
          if (lk_hit) begin
            ind_addr_q <= ind_addr_d;
            ind_mask_q <= ind_mask_d;
            sum_addr_q <= sum_addr_d;
            sum_mask_q <= sum_mask_d;
            isc_q      <= rt_isc_q[lk_idx];
            state_q    <= ST_IND_RD;
          end else begin
            evt_valid_q <= 1'b1;
            evt_kind_q  <= EVT_NO_FUNC;
            evt_fid_q   <= in_fid;
            evt_qual_q  <= 32'(in_vec) << QUAL_VEC_LSB;
          end
        end
        ST_IND_RD: if (mem_gnt_i) state_q <= ST_IND_WAIT;
        ST_IND_WAIT: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            evt_valid_q <= 1'b1;
            evt_kind_q  <= EVT_IND_FAULT;
            evt_fid_q   <= '0;
            evt_qual_q  <= '0;
            state_q     <= ST_SUM_RD;  // summary still attempted
          end else begin
            old_q   <= mem_rdata_i;
            state_q <= ST_IND_WR;
          end
        end
        ST_IND_WR: if (mem_gnt_i) state_q <= ST_SUM_RD;
        ST_SUM_RD: if (mem_gnt_i) state_q <= ST_SUM_WAIT;
        ST_SUM_WAIT: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            evt_valid_q <= 1'b1;
            evt_kind_q  <= EVT_IND_FAULT;
            evt_fid_q   <= '0;
            evt_qual_q  <= '0;
            state_q     <= ST_IDLE;
          end else begin
            old_q   <= mem_rdata_i;
            state_q <= ST_SUM_WR;
          end
        end
        ST_SUM_WR: if (mem_gnt_i) begin
          if (old_q == 8'h00) begin
            irq_valid_q <= 1'b1;
            irq_word_q  <= (32'(isc_q) << IRQ_ISC_LSB) | (32'd1 << IRQ_AI_BIT);
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign on_ind      = (state_q == ST_IND_RD) || (state_q == ST_IND_WAIT) || (state_q == ST_IND_WR);
  assign wr_ready_o  = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_IND_RD) || (state_q == ST_IND_WR) ||
                       (state_q == ST_SUM_RD) || (state_q == ST_SUM_WR);
  assign mem_we_o    = (state_q == ST_IND_WR) || (state_q == ST_SUM_WR);
  assign mem_lock_o  = (state_q != ST_IDLE);
  assign mem_addr_o  = on_ind ? ind_addr_q : sum_addr_q;
  assign mem_wdata_o = old_q | (on_ind ? ind_mask_q : sum_mask_q);
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_valid_q ? 32'hFFFF_FFFF : 32'h0;
  assign irq_valid_o = irq_valid_q;
  assign irq_word_o  = irq_word_q;
  assign evt_valid_o = evt_valid_q;
  assign evt_kind_o  = evt_kind_q;
  assign evt_fid_o   = evt_fid_q;
  assign evt_qual_o  = evt_qual_q;

  // R3
  no_func_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && !lk_hit) |=> (evt_valid_o && !evt_kind_o && !mem_req_o));
  // R10
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && lk_hit) |=> (!wr_ready_o && mem_req_o && !mem_we_o));
  // R6
  locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_lock_o);
  // R7
  irq_after_sum_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> $past(mem_req_o && mem_we_o && mem_gnt_i));
  // R7
  irq_word_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_word_o[31:30] == 2'b10 && irq_word_o[26:0] == 27'd0));
  // R8
  fault_evt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o) |-> (evt_fid_o == '0 && evt_qual_o == 32'd0));
  // R9
  read_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> (rd_valid_o && rd_data_o == 32'hFFFF_FFFF));
endmodule

// File: tb/msi_ind_irq_tb.sv
module msi_ind_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_SZ     = 1024;
  localparam int WDOG       = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        wr_valid = 1'b0, rd_valid = 1'b0, cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0]  cfg_slot = '0;
  logic [23:0] cfg_fid = '0;
  logic [15:0] cfg_ib = '0, cfg_sb = '0;
  logic [11:0] cfg_io = '0, cfg_so = '0;
  logic [2:0]  cfg_isc = '0;

  logic        wr_ready, rd_valid_o, mem_req, mem_we, mem_lock, irq_valid, evt_valid, evt_kind;
  logic [31:0] rd_data, irq_word, evt_qual;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [23:0] evt_fid;

  logic        gnt, rvalid, rerr;
  logic [7:0]  rdata;
  logic [7:0]  lfsr = 8'hA5;

  msi_ind_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rd_valid_i(rd_valid), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data),
    .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_valid_i(cfg_valid), .cfg_fid_i(cfg_fid),
    .cfg_ind_base_i(cfg_ib), .cfg_ind_off_i(cfg_io), .cfg_sum_base_i(cfg_sb),
    .cfg_sum_off_i(cfg_so), .cfg_isc_i(cfg_isc),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_lock_o(mem_lock), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(gnt), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .mem_err_i(rerr),
    .irq_valid_o(irq_valid), .irq_word_o(irq_word),
    .evt_valid_o(evt_valid), .evt_kind_o(evt_kind), .evt_fid_o(evt_fid), .evt_qual_o(evt_qual)
  );

  // stalling grant
  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign gnt = lfsr[0] | lfsr[2];

  // memory model
  logic [7:0]  mem [0:MEM_SZ-1];
  logic [15:0] err_addr = 16'hFFFF;
  logic        clr_en = 1'b0;
  logic [15:0] clr_addr = '0;
  logic        rmw_open;
  int          req_cnt, wr_cnt, lock_viol;
  logic [15:0] w_prev, w_last;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_SZ; i++) mem[i] <= 8'h00;
      rvalid <= 1'b0; rerr <= 1'b0; rdata <= '0; rmw_open <= 1'b0;
      req_cnt <= 0; wr_cnt <= 0; lock_viol <= 0; w_prev <= '0; w_last <= '0;
    end else begin
      rvalid <= 1'b0;
      rerr   <= 1'b0;
      if (clr_en) mem[clr_addr[9:0]] <= 8'h00;
      if (rvalid && rerr) rmw_open <= 1'b0;
      if (rmw_open && !mem_lock) lock_viol <= lock_viol + 1;
      if (mem_req && gnt) begin
        req_cnt <= req_cnt + 1;
        if (!mem_we) begin
          rvalid   <= 1'b1;
          rdata    <= mem[mem_addr[9:0]];
          rerr     <= (mem_addr == err_addr);
          rmw_open <= 1'b1;
        end else begin
          if (!rmw_open) lock_viol <= lock_viol + 1;
          mem[mem_addr[9:0]] <= mem_wdata;
          w_prev   <= w_last;
          w_last   <= mem_addr;
          wr_cnt   <= wr_cnt + 1;
          rmw_open <= 1'b0;
        end
      end
    end
  end

  // output monitor
  int          irq_cnt = 0, evt_cnt = 0;
  logic [31:0] irq_last = '0, evt_qual_last = '0;
  logic [23:0] evt_fid_last = '0;
  logic        evt_kind_last = 1'b0;
  always @(negedge clk) begin
    if (rst_n && irq_valid) begin
      irq_cnt <= irq_cnt + 1; irq_last <= irq_word;
    end
    if (rst_n && evt_valid) begin
      evt_cnt <= evt_cnt + 1; evt_kind_last <= evt_kind;
      evt_fid_last <= evt_fid; evt_qual_last <= evt_qual;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [7:0] exp_mem [0:MEM_SZ-1];
  int dev_slot[4], dev_fid[4], dev_ib[4], dev_io[4], dev_sb[4], dev_so[4], dev_isc[4];

  task automatic cfg(input int slot, input bit v, input int fid, input int ib, input int io,
                     input int sb, input int so, input int isc);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 5'(slot); cfg_valid = v; cfg_fid = 24'(fid);
    cfg_ib = 16'(ib); cfg_io = 12'(io); cfg_sb = 16'(sb); cfg_so = 12'(so); cfg_isc = 3'(isc);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_byte(input int a);
    @(negedge clk);
    clr_en = 1'b1; clr_addr = 16'(a);
    @(negedge clk);
    clr_en = 1'b0;
    exp_mem[a] = 8'h00;
  endtask

  task automatic send(input logic [31:0] data, input bit probe);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
    if (probe) begin
      chk(!wr_ready, "R10 busy after accept", 64'(wr_ready), 0);
      rd_valid = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0;
      chk(rd_valid_o && rd_data == 32'hFFFF_FFFF, "R9 read while busy", 64'(rd_data), 64'hFFFF_FFFF);
    end
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_msg(input int d, input int v, input bit ind_err, input bit sum_err, input bit probe);
    int ia, sa, ib0, n_err;
    logic [7:0] im, sm, old_s;
    bit irq_exp;
    int irq0, evt0, wr0;
    ia = dev_ib[d] + (dev_io[d] + v) / 8;
    im = 8'h80 >> ((dev_io[d] + v) % 8);
    sa = dev_sb[d] + dev_so[d] / 8;
    sm = 8'h80 >> (dev_so[d] % 8);
    ib0 = ind_err ? 1 : 0;
    n_err = ib0 + (sum_err ? 1 : 0);
    err_addr = ind_err ? 16'(ia) : (sum_err ? 16'(sa) : 16'hFFFF);
    if (!ind_err) exp_mem[ia] = exp_mem[ia] | im;
    old_s = exp_mem[sa];
    if (!sum_err) exp_mem[sa] = exp_mem[sa] | sm;
    irq_exp = !sum_err && (old_s == 8'h00);
    irq0 = irq_cnt; evt0 = evt_cnt; wr0 = wr_cnt;
    // R1: vector in the low byte, function id above it
    send({24'(dev_fid[d]), 8'(v)}, probe);
    err_addr = 16'hFFFF;
    chk(mem[ia] == exp_mem[ia], "R1 R4 indicator byte", 64'(mem[ia]), 64'(exp_mem[ia]));
    chk(mem[sa] == exp_mem[sa], "R5 summary byte", 64'(mem[sa]), 64'(exp_mem[sa]));
    chk((irq_cnt - irq0) == (irq_exp ? 1 : 0), "R7 irq count", 64'(irq_cnt - irq0), 64'(irq_exp));
    if (irq_exp)
      chk(irq_last == {2'b10, 3'(dev_isc[d]), 27'd0}, "R7 irq word", 64'(irq_last),
          64'({2'b10, 3'(dev_isc[d]), 27'd0}));
    chk((evt_cnt - evt0) == n_err, "R8 event count", 64'(evt_cnt - evt0), 64'(n_err));
    chk((wr_cnt - wr0) == 2 - n_err, "R6 write count", 64'(wr_cnt - wr0), 64'(2 - n_err));
    if (n_err == 0)
      chk(w_prev == 16'(ia) && w_last == 16'(sa), "R6 write order",
          64'({w_prev, w_last}), 64'({16'(ia), 16'(sa)}));
    if (n_err != 0)
      chk(evt_kind_last && evt_fid_last == 0 && evt_qual_last == 0, "R8 fault event fields",
          64'({evt_kind_last, evt_fid_last}), 64'({1'b1, 24'd0}));
  endtask

  task automatic no_match(input int fid, input int v);
    int evt0, req0;
    evt0 = evt_cnt; req0 = req_cnt;
    send({24'(fid), 8'(v)}, 1'b0);
    chk((evt_cnt - evt0) == 1 && !evt_kind_last, "R3 no-function event", 64'(evt_cnt - evt0), 1);
    chk(evt_fid_last == 24'(fid), "R3 event fid", 64'(evt_fid_last), 64'(fid));
    chk(evt_qual_last == (32'(v) << 16), "R3 event qualifier", 64'(evt_qual_last), 64'(32'(v) << 16));
    chk(req_cnt == req0, "R3 no memory access", 64'(req_cnt - req0), 0);
  endtask

  initial begin
    int bad;
    for (int i = 0; i < MEM_SZ; i++) exp_mem[i] = 8'h00;
    dev_slot = '{2, 4, 7, 31};
    dev_fid  = '{'h10, 'h11, 'h12, 'hABCDEF};
    dev_ib   = '{'h000, 'h040, 'h080, 'h100};
    dev_io   = '{5, 0, 1000, 7};
    dev_sb   = '{'h300, 'h300, 'h310, 'h320};
    dev_so   = '{3, 6, 100, 9};
    dev_isc  = '{2, 7, 0, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(wr_ready && !mem_req && !irq_valid && !evt_valid && !rd_valid_o, "R11 reset state",
        64'({wr_ready, mem_req, irq_valid, evt_valid, rd_valid_o}), 64'h10);

    cfg(1, 1'b0, 'h55, 'h200, 0, 'h200, 0, 1);          // invalid slot
    for (int d = 0; d < 4; d++)
      cfg(dev_slot[d], 1'b1, dev_fid[d], dev_ib[d], dev_io[d], dev_sb[d], dev_so[d], dev_isc[d]);
    cfg(9, 1'b1, 'h10, 'h200, 3, 'h210, 1, 6);          // duplicate id, higher slot

    // R9 idle read
    @(negedge clk); rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
    chk(rd_valid_o && rd_data == 32'hFFFF_FFFF, "R9 idle read", 64'(rd_data), 64'hFFFF_FFFF);

    // R2 R3
    no_match('h55, 'h2A);
    no_match('h999999, 'hFF);
    no_match('h13, 0);

    // sweep every vector on every device
    for (int d = 0; d < 4; d++) begin
      for (int v = 0; v < 256; v++) begin
        if (v % 16 == 0) clear_byte(dev_sb[d] + dev_so[d] / 8);
        run_msg(d, v, 1'b0, 1'b0, v == 0);
      end
    end

    // R8 indicator fault, summary still updated
    clear_byte(dev_sb[0] + dev_so[0] / 8);
    clear_byte(dev_ib[0] + (dev_io[0] + 40) / 8);
    run_msg(0, 40, 1'b1, 1'b0, 1'b0);
    // R8 summary fault, no interrupt
    clear_byte(dev_sb[3] + dev_so[3] / 8);
    clear_byte(dev_ib[3] + (dev_io[3] + 9) / 8);
    run_msg(3, 9, 1'b0, 1'b1, 1'b0);
    // recovery after fault
    run_msg(3, 10, 1'b0, 1'b0, 1'b1);

    // R6
    chk(lock_viol == 0, "R6 lock held across read-modify-write", 64'(lock_viol), 0);
    // R2: duplicate higher slot and invalid slot areas untouched, whole image matches
    bad = 0;
    for (int i = 0; i < MEM_SZ; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, "R2 memory image", 64'(bad), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule